// File: doc/BRIEF.md
# Six-Input Rotating Priority Arbiter

This block chooses one winner among six request lines. Line 0 always wins when it is active, and line 5 wins only when no other line is active. The four lines between them are ranked by a 2-bit selection register. Each value of that register starts the ranking of the middle lines at a different one, and the order is circular. The winner appears in the same cycle as the requests, both as a one-hot grant vector and as a 3-bit index, together with a valid flag.

A mode register sets how the selection register changes. In fixed mode it changes only when software writes it. In rotating mode, each service strobe that acknowledges a middle-line grant moves the selection so that the line just served becomes the lowest of the middle four. Software can write both the selection and the mode through simple write strobes. A selection write always overrides the automatic update in the same cycle.

Top module: `six_way_rotor_arb`

## Requirements
- R1: After reset the selection register reads 00 and the mode register reads 0 (fixed).
- R2: When request 0 is active, grant index 0 is issued (grant bit 0 set), whatever the other requests and the selection value are.
- R3: Request 5 is granted (index 5) only when requests 0 to 4 are all inactive.
- R4: Among requests 1 to 4 the ranking from highest to lowest is: selection 00 → 1,2,3,4; 01 → 2,3,4,1; 10 → 3,4,1,2; 11 → 4,1,2,3.
- R5: With no request active, the grant vector is all zeros, the index is 0 and the valid output is low.
- R6: The grant vector has at most one bit set. That bit is at the position given by the index, and the request on that line is active.
- R7: In fixed mode (mode 0) the selection register changes only through a selection write.
- R8: In rotating mode (mode 1), a clock edge with the service strobe high and a valid grant of index 1, 2, 3 or 4 loads the selection with 01, 10, 11 or 00 respectively.
- R9: Servicing a grant of index 0 or 5 leaves the selection unchanged in either mode.
- R10: A service strobe while no grant is valid leaves the selection unchanged.
- R11: A selection write on an edge loads the written value, even if a rotation update would occur on the same edge.
- R12: A mode write on an edge loads the mode register. The new mode governs rotation from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Request lines, bit n = request n |
| serve_i | input | 1 | Service strobe acknowledging the current grant |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_d_i | input | 1 | Mode write data (1 = rotating) |
| sel_wr_i | input | 1 | Selection register write strobe |
| sel_d_i | input | 2 | Selection write data |
| grant_o | output | 6 | One-hot grant vector |
| grant_idx_o | output | 3 | Index of the granted line |
| grant_vld_o | output | 1 | A grant is being issued |
| sel_o | output | 2 | Current selection register |
| mode_o | output | 1 | Current mode register |

## Verification
On every cycle the assertions check the shape of the grant: it is one-hot and tied to an active request, the index agrees with it, line 0 dominates and line 5 yields. They also check how the selection register evolves: it holds in fixed mode, holds on edge-line service, follows the rotation rule and yields to writes. The exact ranking of the middle four under each selection value is shown only by the bench's directed patterns and its random comparison against a reference model. The same applies to the chained rotation sequence, where each served middle line drops to last.

// File: rtl/rotor_arb_pkg.sv
package rotor_arb_pkg;

  // Request number held by middle slot k (0 = highest) for a selection value.
  function automatic int mid_slot_line(input int sel, input int k, input int num_mid);
    return 1 + ((sel + k) % num_mid);
  endfunction

endpackage

// File: rtl/rotor_pick.sv
module rotor_pick #(
  parameter int NUM_MID = 4,
  localparam int N      = NUM_MID + 2,
  localparam int SEL_W  = $clog2(NUM_MID),
  localparam int IDX_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  import rotor_arb_pkg::*;

  logic [IDX_W-1:0] slot_line [NUM_MID];
  logic [NUM_MID-1:0] slot_req;

  // One mux per middle slot: which request line sits at that rank.
  for (genvar k = 0; k < NUM_MID; k++) begin : g_slot
    always_comb begin
      slot_line[k] = IDX_W'(mid_slot_line(int'(sel_i), k, NUM_MID));
      slot_req[k]  = req_i[slot_line[k]];
    end
  end

  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    if (req_i[0]) begin
      idx_o = '0;
      vld_o = 1'b1;
    end else begin
      for (int k = 0; k < NUM_MID; k++) begin
        if (!vld_o && slot_req[k]) begin
          idx_o = slot_line[k];
          vld_o = 1'b1;
        end
      end
      if (!vld_o && req_i[N-1]) begin
        idx_o = IDX_W'(N-1);
        vld_o = 1'b1;
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (vld_o) grant_o[idx_o] = 1'b1;
  end

  AST_TOP_WINS:   assert property (@(posedge clk) disable iff (rst) req_i[0] |-> (grant_o[0] && idx_o == '0)); // R2
  AST_BOTTOM_YIELDS: assert property (@(posedge clk) disable iff (rst) grant_o[N-1] |-> (req_i[N-2:0] == '0)); // R3
  AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o) && ((grant_o & ~req_i) == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (req_i == '0) |-> (!vld_o && grant_o == '0)); // R5

endmodule

// File: rtl/rotor_sel_reg.sv
module rotor_sel_reg #(
  parameter int NUM_MID = 4,
  localparam int N      = NUM_MID + 2,
  localparam int SEL_W  = $clog2(NUM_MID),
  localparam int IDX_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serve_i,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             mode_wr_i,
  input  logic             mode_d_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_d_i,
  output logic [SEL_W-1:0] sel_q,
  output logic             mode_q
);

  logic             mid_hit;
  logic             rotate;
  logic [SEL_W-1:0] rot_sel;

  always_comb begin
    mid_hit = (idx_i >= IDX_W'(1)) && (idx_i <= IDX_W'(NUM_MID));
    rotate  = mode_q && serve_i && vld_i && mid_hit;
    // Served line m becomes the last middle slot: selection = m mod NUM_MID.
    rot_sel = SEL_W'(int'(idx_i) % NUM_MID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (sel_wr_i)    sel_q <= sel_d_i;
      else if (rotate) sel_q <= rot_sel;
      if (mode_wr_i)   mode_q <= mode_d_i;
    end
  end

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst) (!mode_q && !sel_wr_i) |=> $stable(sel_q)); // R7
  AST_EDGE_KEEP:  assert property (@(posedge clk) disable iff (rst) (serve_i && vld_i && !mid_hit && !sel_wr_i) |=> $stable(sel_q)); // R9
  AST_NOVLD_KEEP: assert property (@(posedge clk) disable iff (rst) (!vld_i && !sel_wr_i) |=> $stable(sel_q)); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) sel_wr_i |=> (sel_q == $past(sel_d_i))); // R11
  AST_MODE_LOAD:  assert property (@(posedge clk) disable iff (rst) mode_wr_i |=> (mode_q == $past(mode_d_i))); // R12

endmodule

// File: rtl/six_way_rotor_arb.sv
module six_way_rotor_arb #(
  parameter int NUM_MID = 4,
  localparam int N      = NUM_MID + 2,
  localparam int SEL_W  = $clog2(NUM_MID),
  localparam int IDX_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_i,
  input  logic             serve_i,
  input  logic             mode_wr_i,
  input  logic             mode_d_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_d_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_vld_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             mode_o
);

  logic [SEL_W-1:0] sel_q;
  logic             mode_q;

  rotor_pick #(.NUM_MID(NUM_MID)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .sel_i   (sel_q),
    .grant_o (grant_o),
    .idx_o   (grant_idx_o),
    .vld_o   (grant_vld_o)
  );

  rotor_sel_reg #(.NUM_MID(NUM_MID)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .serve_i   (serve_i),
    .vld_i     (grant_vld_o),
    .idx_i     (grant_idx_o),
    .mode_wr_i (mode_wr_i),
    .mode_d_i  (mode_d_i),
    .sel_wr_i  (sel_wr_i),
    .sel_d_i   (sel_d_i),
    .sel_q     (sel_q),
    .mode_q    (mode_q)
  );

  assign sel_o  = sel_q;
  assign mode_o = mode_q;

  AST_ROTATE_RULE: assert property (@(posedge clk) disable iff (rst)
    (mode_o && serve_i && grant_vld_o && !sel_wr_i && grant_idx_o != '0 && grant_idx_o != IDX_W'(N-1))
    |=> (int'(sel_o) == int'($past(grant_idx_o)) % NUM_MID)); // R8
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (sel_o == '0 && !mode_o)); // R1

endmodule

// File: tb/six_way_rotor_arb_bench.sv
module six_way_rotor_arb_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] req = '0;
  logic       serve = 1'b0, mode_wr = 1'b0, mode_d = 1'b0, sel_wr = 1'b0;
  logic [1:0] sel_d = '0;
  logic [5:0] grant;
  logic [2:0] gidx;
  logic       gvld;
  logic [1:0] sel;
  logic       mode;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_sel = '0;
  logic       m_mode = 1'b0;
  string      sel_tag = "R1";

  always #10 clk = ~clk;

  six_way_rotor_arb u_six_way_rotor_arb (
    .clk(clk), .rst(rst), .req_i(req), .serve_i(serve),
    .mode_wr_i(mode_wr), .mode_d_i(mode_d), .sel_wr_i(sel_wr), .sel_d_i(sel_d),
    .grant_o(grant), .grant_idx_o(gidx), .grant_vld_o(gvld),
    .sel_o(sel), .mode_o(mode)
  );

  function automatic int ref_idx(input logic [5:0] r, input logic [1:0] s);
    if (r[0]) return 0;
    for (int k = 0; k < 4; k++) begin
      int m = 1 + ((int'(s) + k) % 4);
      if (r[m]) return m;
    end
    if (r[5]) return 5;
    return -1;
  endfunction

  function automatic string grant_tag(input logic [5:0] r);
    if (r[0]) return "R2";
    if (r == 6'b100000) return "R3";
    if (r == 6'b000000) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check at mid-low phase, advance the model at the rising edge.
  task automatic cycle(input logic [5:0] r, input logic sv, input logic mw, input logic md,
                       input logic sw, input logic [1:0] sd);
    int e;
    logic [5:0] eg;
    @(negedge clk);
    req = r; serve = sv; mode_wr = mw; mode_d = md; sel_wr = sw; sel_d = sd;
    #2;
    check(sel_tag, int'(sel), int'(m_sel));
    check("R12", int'(mode), int'(m_mode));
    e  = ref_idx(r, m_sel);
    eg = (e < 0) ? 6'b0 : (6'b1 << e);
    check(grant_tag(r), int'(gvld), (e >= 0) ? 1 : 0);
    check("R6", int'(grant), int'(eg));
    check(grant_tag(r), int'(gidx), (e < 0) ? 0 : e);
    @(posedge clk);
    if (sw) begin
      m_sel = sd; sel_tag = "R11";
    end else if (m_mode && sv && e >= 1 && e <= 4) begin
      m_sel = 2'(e % 4); sel_tag = "R8";
    end else if (sv && (e == 0 || e == 5)) sel_tag = "R9";
    else if (sv && e < 0) sel_tag = "R10";
    else if (!m_mode) sel_tag = "R7";
    if (mw) m_mode = md;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #2;
    check("R1", int'(sel), 0);
    check("R1", int'(mode), 0);

    // R4: every selection value with the four middle lines requested, fixed mode.
    for (int s = 0; s < 4; s++) begin
      cycle(6'b000000, 1'b0, 1'b0, 1'b0, 1'b1, 2'(s));
      cycle(6'b011110, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
      cycle(6'b010010, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
      cycle(6'b100001, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      cycle(6'b100000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
      cycle(6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    end
    // R12 then R8 chain: served middle line drops to last.
    cycle(6'b000000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00);
    for (int i = 0; i < 6; i++) cycle(6'b011110, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    // R9 / R10 in rotating mode
    cycle(6'b111111, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    cycle(6'b100000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    cycle(6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00);
    // R11: write and rotation on the same edge
    cycle(6'b000100, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01);
    cycle(6'b000000, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      if (($urandom % 4) == 0) r[0] = 1'b0;
      if (($urandom % 3) == 0) r[4:0] = '0;
      cycle(r, 1'($urandom % 2), ($urandom % 10) == 0, 1'($urandom),
            ($urandom % 8) == 0, 2'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule